// File: doc/BRIEF.md
# Cascaded Transition-Filtered Status Register

This block is a three-level tree of 16-bit status registers. Each level samples a vector of live status flags into a condition register. It picks out edges on those flags with two per-bit masks: one for rising edges and one for falling edges. Each qualified edge is latched into a sticky event register. The event bits that an enable mask lets through are OR-ed into one summary bit.

The summary of the lowest level (leaf) replaces bit 0 of the middle level's condition input. The middle level's summary replaces bit 10 of the top level (root) condition input. A change at the bottom of the tree therefore shows up, a few clocks later, as an event at the root.

Software-side logic reaches the masks through a one-cycle write port. A combinational read port returns any mask, the condition sample or the event register of any level. Reading the event register returns its value and clears it in the same cycle.

Top module: `stat_tree`

## Requirements
- R1: The enable, rising-edge and falling-edge masks of every level accept any 16-bit value written through the write port and read back exactly that value; writing 6 sets bits 1 and 2 only. Register select codes: 0 enable, 1 rising mask, 2 falling mask, 3 condition, 4 event. Level codes: 0 leaf, 1 middle, 2 root.
- R2: With its rising-edge mask bit set, a 0-to-1 change of a condition bit sets the matching event bit.
- R3: With its falling-edge mask bit set, a 1-to-0 change of a condition bit sets the matching event bit. With that mask bit clear, a falling change sets nothing.
- R4: A bit with both mask bits set records either edge. A bit with neither mask bit set never records an event.
- R5: Event bits stay set until the event register of their level is read. The read returns the value before clearing. An event detected in the same cycle as the clearing read is still recorded.
- R6: A level's summary output is 1 exactly when some event bit is 1 and its enable bit is also 1. It follows a mask or event change with no added register.
- R7: The leaf summary drives middle condition bit 0, and the middle summary drives root condition bit 10, each one clock later. The external input at those two bit positions has no effect.
- R8: Each condition register shows the live input one clock after it is applied.
- R9: After reset, every event register and enable mask is 0, every rising mask is 0xFFFF and every falling mask is 0. No event is produced from the first sample taken after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| leaf_cond_i | input | 16 | Live status flags of the leaf level |
| mid_cond_i | input | 16 | Live status flags of the middle level (bit 0 unused) |
| root_cond_i | input | 16 | Live status flags of the root level (bit 10 unused) |
| wr_en_i | input | 1 | Mask write strobe |
| wr_node_i | input | 2 | Level selected for the write |
| wr_sel_i | input | 3 | Register selected for the write |
| wr_data_i | input | 16 | Write value |
| rd_en_i | input | 1 | Read strobe; with select 4 it clears the selected event register |
| rd_node_i | input | 2 | Level selected for the read |
| rd_sel_i | input | 3 | Register selected for the read |
| rd_data_o | output | 16 | Read value, combinational |
| sum_o | output | 3 | Summary bits: leaf, middle, root |

## Verification
A flag change applied after a falling clock edge reaches the condition register one rising edge later. It sets the event bit on the second rising edge. A summary moves at the edge where its event or enable register changes. Each cascade hop adds one clock to reach the parent's condition register and one more to reach the parent's event register.

The bench drives inputs and samples outputs at falling edges. It counts the exact number of rising edges between the two for each of these results. For the condition register and the cascade, it checks both the value before the due edge and the value after it. A clearing read is checked in a cycle where a new edge is detected, so that the new event is seen to survive the clear.

// File: rtl/stat_pkg.sv
package stat_pkg;

  typedef enum logic [2:0] {
    SEL_EN   = 3'd0,
    SEL_RISE = 3'd1,
    SEL_FALL = 3'd2,
    SEL_COND = 3'd3,
    SEL_EVT  = 3'd4
  } reg_sel_e;

  localparam int unsigned TREE_LEVELS = 3;

endpackage

// File: rtl/stat_edge_det.sv
module stat_edge_det #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_i,
  input  logic [W-1:0] rise_mask_i,
  input  logic [W-1:0] fall_mask_i,
  output logic [W-1:0] cond_o,
  output logic [W-1:0] hit_o
);

  function automatic logic [W-1:0] edge_hits(
    input logic [W-1:0] prev, input logic [W-1:0] cur,
    input logic [W-1:0] rise, input logic [W-1:0] fall);
    return (~prev & cur & rise) | (prev & ~cur & fall);
  endfunction

  logic [W-1:0] cond_q, prev_q;
  logic         cond_vld_q, prev_vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond_q     <= '0;
      prev_q     <= '0;
      cond_vld_q <= 1'b0;
      prev_vld_q <= 1'b0;
    end else begin
      cond_q     <= raw_i;
      prev_q     <= cond_q;
      cond_vld_q <= 1'b1;
      prev_vld_q <= cond_vld_q;
    end
  end

  assign cond_o = cond_q;
  assign hit_o  = prev_vld_q ? edge_hits(prev_q, cond_q, rise_mask_i, fall_mask_i) : '0;

endmodule

// File: rtl/stat_node.sv
module stat_node
  import stat_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_i,
  input  logic         wr_en_i,
  input  reg_sel_e     wr_sel_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         clr_i,
  output logic [W-1:0] en_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o,
  output logic [W-1:0] cond_o,
  output logic [W-1:0] evt_o,
  output logic [W-1:0] hit_o,
  output logic         sum_o
);

  function automatic logic [W-1:0] next_event(
    input logic [W-1:0] evt, input logic [W-1:0] hit, input logic clr);
    return (clr ? '0 : evt) | hit;
  endfunction

  function automatic logic summarize(input logic [W-1:0] evt, input logic [W-1:0] en);
    return |(evt & en);
  endfunction

  logic [W-1:0] en_q, rise_q, fall_q, evt_q;

  stat_edge_det #(.W(W)) u_edge (
    .clk         (clk),
    .rst_n       (rst_n),
    .raw_i       (raw_i),
    .rise_mask_i (rise_q),
    .fall_mask_i (fall_q),
    .cond_o      (cond_o),
    .hit_o       (hit_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      rise_q <= '1;
      fall_q <= '0;
    end else if (wr_en_i) begin
      case (wr_sel_i)
        SEL_EN:   en_q   <= wr_data_i;
        SEL_RISE: rise_q <= wr_data_i;
        SEL_FALL: fall_q <= wr_data_i;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= '0;
    else        evt_q <= next_event(evt_q, hit_o, clr_i);
  end

  assign en_o   = en_q;
  assign rise_o = rise_q;
  assign fall_o = fall_q;
  assign evt_o  = evt_q;
  assign sum_o  = summarize(evt_q, en_q);

endmodule

// File: rtl/stat_tree.sv
module stat_tree
  import stat_pkg::*;
#(
  parameter int unsigned W        = 16,
  parameter int unsigned LEAF_BIT = 0,
  parameter int unsigned MID_BIT  = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] leaf_cond_i,
  input  logic [W-1:0] mid_cond_i,
  input  logic [W-1:0] root_cond_i,
  input  logic         wr_en_i,
  input  logic [1:0]   wr_node_i,
  input  logic [2:0]   wr_sel_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         rd_en_i,
  input  logic [1:0]   rd_node_i,
  input  logic [2:0]   rd_sel_i,
  output logic [W-1:0] rd_data_o,
  output logic [2:0]   sum_o
);

  localparam int unsigned NODES = TREE_LEVELS;

  function automatic logic [W-1:0] splice(input logic [W-1:0] v, input int unsigned pos,
                                          input logic b);
    logic [W-1:0] r;
    r      = v;
    r[pos] = b;
    return r;
  endfunction

  function automatic int unsigned link_pos(input int unsigned level);
    return (level == 1) ? LEAF_BIT : MID_BIT;
  endfunction

  logic [NODES-1:0][W-1:0] cond_in_w, en_w, rise_w, fall_w, cond_w, evt_w, hit_w;
  logic [NODES-1:0]        sum_w, clr_w, wr_w;

  assign cond_in_w[0] = leaf_cond_i;
  assign cond_in_w[1] = mid_cond_i;
  assign cond_in_w[2] = root_cond_i;

  for (genvar g = 0; g < NODES; g++) begin : g_node
    logic [W-1:0] raw;
    if (g == 0) begin : g_leaf
      assign raw = cond_in_w[g];
    end else begin : g_child
      assign raw = splice(cond_in_w[g], link_pos(g), sum_w[g-1]);
    end

    assign clr_w[g] = rd_en_i && (rd_sel_i == SEL_EVT) && (rd_node_i == 2'(g));
    assign wr_w[g]  = wr_en_i && (wr_node_i == 2'(g));

    stat_node #(.W(W)) u_node (
      .clk       (clk),
      .rst_n     (rst_n),
      .raw_i     (raw),
      .wr_en_i   (wr_w[g]),
      .wr_sel_i  (reg_sel_e'(wr_sel_i)),
      .wr_data_i (wr_data_i),
      .clr_i     (clr_w[g]),
      .en_o      (en_w[g]),
      .rise_o    (rise_w[g]),
      .fall_o    (fall_w[g]),
      .cond_o    (cond_w[g]),
      .evt_o     (evt_w[g]),
      .hit_o     (hit_w[g]),
      .sum_o     (sum_w[g])
    );
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_node_i < 2'(NODES)) begin
      case (reg_sel_e'(rd_sel_i))
        SEL_EN:   rd_data_o = en_w[rd_node_i];
        SEL_RISE: rd_data_o = rise_w[rd_node_i];
        SEL_FALL: rd_data_o = fall_w[rd_node_i];
        SEL_COND: rd_data_o = cond_w[rd_node_i];
        SEL_EVT:  rd_data_o = evt_w[rd_node_i];
        default:  rd_data_o = '0;
      endcase
    end
  end

  assign sum_o = sum_w;

endmodule

// File: rtl/stat_tree_chk.sv
module stat_tree_chk #(
  parameter int unsigned W        = 16,
  parameter int unsigned NODES    = 3,
  parameter int unsigned LEAF_BIT = 0,
  parameter int unsigned MID_BIT  = 10
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NODES-1:0][W-1:0] evt_w,
  input logic [NODES-1:0][W-1:0] hit_w,
  input logic [NODES-1:0][W-1:0] rise_w,
  input logic [NODES-1:0][W-1:0] fall_w,
  input logic [NODES-1:0][W-1:0] cond_w,
  input logic [NODES-1:0]        clr_w,
  input logic [NODES-1:0]        sum_w
);

  for (genvar g = 0; g < NODES; g++) begin : g_chk
    // R5
    evt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_w[g] |=> ((evt_w[g] & $past(evt_w[g])) == $past(evt_w[g])));

    // R2
    hit_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_w[g] != '0) |=> ((evt_w[g] & $past(hit_w[g])) == $past(hit_w[g])));

    // R5
    evt_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_w[g] && hit_w[g] == '0) |=> (evt_w[g] == '0));

    // R4
    unmasked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((hit_w[g] & ~(rise_w[g] | fall_w[g])) == '0));
  end

  // R7
  leaf_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cond_w[1][LEAF_BIT] == $past(sum_w[0]));

  // R7
  mid_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cond_w[2][MID_BIT] == $past(sum_w[1]));

endmodule

bind stat_tree stat_tree_chk #(
  .W(W), .NODES(NODES), .LEAF_BIT(LEAF_BIT), .MID_BIT(MID_BIT)
) chk_i (
  .clk    (clk),
  .rst_n  (rst_n),
  .evt_w  (evt_w),
  .hit_w  (hit_w),
  .rise_w (rise_w),
  .fall_w (fall_w),
  .cond_w (cond_w),
  .clr_w  (clr_w),
  .sum_w  (sum_w)
);

// File: tb/stat_tree_tb_top.sv
module stat_tree_tb_top;

  localparam int W = 16;
  localparam logic [2:0] S_EN = 3'd0, S_RISE = 3'd1, S_FALL = 3'd2, S_COND = 3'd3, S_EVT = 3'd4;
  localparam logic [1:0] LEAF = 2'd0, MID = 2'd1, ROOT = 2'd2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] leaf_cond_i = '0, mid_cond_i = '0, root_cond_i = '0;
  logic         wr_en_i = 1'b0;
  logic [1:0]   wr_node_i = '0;
  logic [2:0]   wr_sel_i = '0;
  logic [W-1:0] wr_data_i = '0;
  logic         rd_en_i = 1'b0;
  logic [1:0]   rd_node_i = '0;
  logic [2:0]   rd_sel_i = '0;
  logic [W-1:0] rd_data_o;
  logic [2:0]   sum_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  stat_tree dut_i (.*);

  // mask writes: {level, select, value}
  localparam logic [20:0] VEC [8] = '{
    {LEAF, S_EN,   16'h0006}, {LEAF, S_RISE, 16'h0000},
    {LEAF, S_FALL, 16'hFFFF}, {MID,  S_EN,   16'hFFFF},
    {MID,  S_RISE, 16'h0006}, {ROOT, S_FALL, 16'h8001},
    {ROOT, S_EN,   16'h0000}, {ROOT, S_RISE, 16'h1234}
  };

  task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] node, input logic [2:0] sel, input logic [W-1:0] d);
    wr_en_i = 1'b1; wr_node_i = node; wr_sel_i = sel; wr_data_i = d;
    tick(1);
    wr_en_i = 1'b0;
  endtask

  task automatic peek(input logic [1:0] node, input logic [2:0] sel, output logic [W-1:0] d);
    rd_en_i = 1'b0; rd_node_i = node; rd_sel_i = sel;
    #1 d = rd_data_o;
  endtask

  task automatic clear_read(input logic [1:0] node, output logic [W-1:0] d);
    rd_en_i = 1'b1; rd_node_i = node; rd_sel_i = S_EVT;
    #1 d = rd_data_o;
    tick(1);
    rd_en_i = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick(2);
    rst_n = 1'b1;
    tick(3);
  endtask

  initial begin
    logic [W-1:0] v;
    leaf_cond_i = 16'hFFFF; mid_cond_i = 16'h0001; root_cond_i = 16'h0400;
    do_reset();

    // R9 reset values, no event from the first sample; R7 external link bits ignored
    for (int n = 0; n < 3; n++) begin
      peek(2'(n), S_EN, v);   check("R9 enable reset", v, 16'h0000);
      peek(2'(n), S_RISE, v); check("R9 rise reset", v, 16'hFFFF);
      peek(2'(n), S_FALL, v); check("R9 fall reset", v, 16'h0000);
      peek(2'(n), S_EVT, v);  check("R9 event reset", v, 16'h0000);
    end
    check("R9 summaries low", {13'd0, sum_o}, 16'h0000);
    peek(MID, S_COND, v);  check("R7 mid link input ignored", v, 16'h0000);
    peek(ROOT, S_COND, v); check("R7 root link input ignored", v, 16'h0000);

    // R1 mask write table
    for (int i = 0; i < 8; i++) begin
      wr(VEC[i][20:19], VEC[i][18:16], VEC[i][15:0]);
      peek(VEC[i][20:19], VEC[i][18:16], v);
      check("R1 mask readback", v, VEC[i][15:0]);
    end
    do_reset();

    // R3 falling edges with empty falling mask do nothing
    leaf_cond_i = 16'h0000; tick(3);
    peek(LEAF, S_EVT, v); check("R3 fall without mask", v, 16'h0000);

    // R2 rising edge: event due two edges after the change
    leaf_cond_i = 16'h0008; tick(1);
    peek(LEAF, S_EVT, v); check("R2 not yet", v, 16'h0000);
    tick(1);
    clear_read(LEAF, v); check("R2 rise recorded", v, 16'h0008);
    peek(LEAF, S_EVT, v); check("R5 cleared by read", v, 16'h0000);

    // R5 clearing read in the cycle a new edge is detected
    leaf_cond_i = 16'h0009; tick(3);
    leaf_cond_i = 16'h000B; tick(1);
    clear_read(LEAF, v);  check("R5 read value before clear", v, 16'h0001);
    peek(LEAF, S_EVT, v); check("R5 new event survives clear", v, 16'h0002);
    clear_read(LEAF, v);  check("R5 sticky until read", v, 16'h0002);

    // R6 summary gated by enable
    leaf_cond_i = 16'h000F; tick(3);
    check("R6 disabled summary", {15'd0, sum_o[0]}, 16'h0000);
    wr(LEAF, S_EN, 16'h0004);
    check("R6 enabled summary", {15'd0, sum_o[0]}, 16'h0001);
    wr(LEAF, S_EN, 16'h0002);
    check("R6 other bit enabled", {15'd0, sum_o[0]}, 16'h0000);
    wr(LEAF, S_EN, 16'h0004);
    check("R6 re-enabled", {15'd0, sum_o[0]}, 16'h0001);

    // R7 cascade leaf -> mid bit 0 -> root bit 10
    peek(MID, S_COND, v); check("R7 mid link before edge", v, 16'h0000);
    tick(1);
    peek(MID, S_COND, v); check("R7 mid link after edge", v, 16'h0001);
    tick(1);
    peek(MID, S_EVT, v);  check("R7 mid event", v, 16'h0001);
    check("R7 mid summary disabled", {15'd0, sum_o[1]}, 16'h0000);
    wr(MID, S_EN, 16'h0001);
    check("R7 mid summary", {15'd0, sum_o[1]}, 16'h0001);
    peek(ROOT, S_COND, v); check("R7 root link before edge", v, 16'h0000);
    tick(1);
    peek(ROOT, S_COND, v); check("R7 root link after edge", v, 16'h0400);
    tick(1);
    peek(ROOT, S_EVT, v);  check("R7 root event", v, 16'h0400);
    clear_read(LEAF, v);   check("R7 leaf read", v, 16'h0004);
    check("R7 leaf summary falls", {15'd0, sum_o[0]}, 16'h0000);
    peek(MID, S_COND, v);  check("R7 mid link holds", v, 16'h0001);
    tick(1);
    peek(MID, S_COND, v);  check("R7 mid link falls", v, 16'h0000);

    // R8 condition delay
    root_cond_i = 16'h0404;
    peek(ROOT, S_COND, v); check("R8 cond before edge", v, 16'h0400);
    tick(1);
    peek(ROOT, S_COND, v); check("R8 cond after edge", v, 16'h0404);

    // R4 both masks / neither mask on the middle level
    clear_read(MID, v); check("R4 mid clear", v, 16'h0001);
    wr(MID, S_RISE, 16'h0020);
    wr(MID, S_FALL, 16'h0020);
    mid_cond_i = 16'h0061; tick(2);
    clear_read(MID, v); check("R4 rise with both masks", v, 16'h0020);
    mid_cond_i = 16'h0001; tick(2);
    clear_read(MID, v); check("R4 fall with both masks", v, 16'h0020);

    // R3 falling mask on the leaf
    wr(LEAF, S_RISE, 16'h0000);
    wr(LEAF, S_FALL, 16'h0010);
    leaf_cond_i = 16'h001F; tick(3);
    clear_read(LEAF, v); check("R3 rise without rise mask", v, 16'h0000);
    leaf_cond_i = 16'h0000; tick(2);
    clear_read(LEAF, v); check("R3 fall recorded", v, 16'h0010);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule